// File: doc/BRIEF.md
# Move-Bus Instruction Fetch Unit with Constant Register

This block is the fetch stage of a processor whose only instruction is a move between functional units on a shared bus. It holds the program counter. Each cycle it issues one read to a synchronous program memory and passes the returned 32-bit move word to the transfer controller. The unit also sits on the move bus with its own unit address. Reading it returns the program counter or a 32-bit constant register. Writing its program-counter subunit performs a jump.

The constant register is filled from the instruction stream in two ways. A single-word short literal is a word whose condition field holds the code that no ordinary move may use. Its low 28 bits are zero-extended into the register. A long literal is an ordinary move aimed at the unit's constant subunit. The word that follows it in memory is taken whole as data and is never executed. A bus stall freezes the whole unit.

The program memory port is assumed to hold its read data while its enable is low.

Top module: `move_fetch_unit`

## Requirements
- R1: While `rst` is high the program counter and the constant register read as zero and no fetch is issued. In the first cycle after `rst` falls, a fetch is issued from address 0.
- R2: Every issued fetch advances the program counter by one. The word arrives on `imem_data` in the next cycle. An ordinary move word (condition field [31:28] in 0..14) that is not a long-literal payload is presented with `instr_valid` high and `instr_word` equal to the memory word.
- R3: A returned word with condition field [31:28] equal to 15 is not presented. Its bits [27:0], zero-extended, become the constant register at the next edge.
- R4: A presented word with condition 0..14, destination unit field [27:20] equal to `UNIT_ADDR` and destination subunit field [19:16] equal to 1 is a long load, whatever its condition. The next word in memory is written whole into the constant register and is never presented, even if its top four bits are 15.
- R5: A bus write (`wr_en`, `wr_unit` = `UNIT_ADDR`, `wr_sub` = 0) without stall loads the program counter with `wr_data`. No fetch is issued in that cycle, and the word returning in that cycle is dropped. The next fetch comes from the target, and its word is presented two cycles after the write.
- R6: Bus writes to subunit 1 or to any subunit other than 0 change neither the program counter sequence nor the constant register.
- R7: A read with `rd_unit` = `UNIT_ADDR` returns the program counter for `rd_sub` = 0 and the constant register for `rd_sub` = 1, with `rd_hit` high. Any other read gives `rd_hit` low and `rd_data` zero.
- R8: While `stall` is high no fetch is issued, `instr_valid` is low, bus writes are ignored, and the program counter, the constant register and the pending word all hold. When `stall` falls, the held word is presented again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Bus stall; freezes the unit |
| imem_en | output | 1 | Program memory read enable |
| imem_addr | output | IMEM_AW | Program memory read address |
| imem_data | input | 32 | Program memory read data, one cycle after the enable |
| instr_valid | output | 1 | A move word is presented to the transfer controller |
| instr_word | output | 32 | Presented move word |
| wr_en | input | 1 | Bus write strobe |
| wr_unit | input | 8 | Bus destination unit address |
| wr_sub | input | 4 | Bus destination subunit |
| wr_data | input | 32 | Bus write data |
| rd_unit | input | 8 | Bus source unit address |
| rd_sub | input | 4 | Bus source subunit |
| rd_data | output | 32 | Bus read data (zero when not selected) |
| rd_hit | output | 1 | This unit drives the source value |

## Verification
Some internal errors show up in the very next cycle. A wrong pending-word kind either presents a literal payload as a move or swallows a real move. A wrong program counter breaks the address sequence on `imem_addr`. Both are caught by comparing the stream of presented words against a reference walk of the same program. An error in the constant register only becomes visible once the register is read. For that reason the bench holds the read port on subunit 1 and compares it at every presented word. A literal captured one word late, or not at all, therefore fails at the next presented move.

// File: rtl/move_fetch_pkg.sv
`timescale 1ns/1ps
package move_fetch_pkg;

    localparam int WORD_W    = 32;
    localparam int UNIT_W    = 8;
    localparam int SUB_W     = 4;
    localparam int COND_W    = 4;
    localparam int SHORT_W   = WORD_W - COND_W;

    localparam logic [COND_W-1:0] COND_SHORT_LIT = 4'hF;
    localparam logic [SUB_W-1:0]  SUB_PC         = 4'd0;
    localparam logic [SUB_W-1:0]  SUB_LIT        = 4'd1;

    // Field layout of a move word; the decoder depends on cond and destination.
    typedef struct packed {
        logic [COND_W-1:0] cond;
        logic [UNIT_W-1:0] dst_unit;
        logic [SUB_W-1:0]  dst_sub;
        logic [UNIT_W-1:0] src_unit;
        logic [SUB_W-1:0]  src_sub;
        logic [3:0]        spare;
    } move_word_t;

    // What the word on the memory return path turns out to be this cycle.
    typedef enum logic [1:0] {
        RET_NONE,
        RET_INSTR,
        RET_SHORT,
        RET_LONG
    } ret_kind_e;

    function automatic logic is_short_lit(input logic [WORD_W-1:0] w);
        move_word_t m;
        m = w;
        return m.cond == COND_SHORT_LIT;
    endfunction

    function automatic logic is_long_load(input logic [WORD_W-1:0] w,
                                          input logic [UNIT_W-1:0] self);
        move_word_t m;
        m = w;
        return (m.cond != COND_SHORT_LIT) && (m.dst_unit == self) && (m.dst_sub == SUB_LIT);
    endfunction

    function automatic logic [WORD_W-1:0] short_value(input logic [WORD_W-1:0] w);
        return {{COND_W{1'b0}}, w[SHORT_W-1:0]};
    endfunction

endpackage

// File: rtl/move_fetch_bus_port.sv
`timescale 1ns/1ps
module move_fetch_bus_port
    import move_fetch_pkg::*;
#(
    parameter logic [UNIT_W-1:0] UNIT_ADDR = 8'h01
) (
    input  logic              stall,
    input  logic              wr_en,
    input  logic [UNIT_W-1:0] wr_unit,
    input  logic [SUB_W-1:0]  wr_sub,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [UNIT_W-1:0] rd_unit,
    input  logic [SUB_W-1:0]  rd_sub,
    input  logic [WORD_W-1:0] pc_val,
    input  logic [WORD_W-1:0] lit_val,
    output logic              jump,
    output logic [WORD_W-1:0] jump_target,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_hit
);

    logic rd_unit_match;

    always_comb begin
        jump        = wr_en && !stall && (wr_unit == UNIT_ADDR) && (wr_sub == SUB_PC);
        jump_target = wr_data;
    end

    always_comb begin
        rd_unit_match = (rd_unit == UNIT_ADDR);
        rd_hit        = 1'b0;
        rd_data       = '0;
        if (rd_unit_match) begin
            unique case (rd_sub)
                SUB_PC: begin
                    rd_hit  = 1'b1;
                    rd_data = pc_val;
                end
                SUB_LIT: begin
                    rd_hit  = 1'b1;
                    rd_data = lit_val;
                end
                default: begin
                    rd_hit  = 1'b0;
                    rd_data = '0;
                end
            endcase
        end
    end

endmodule

// File: rtl/move_fetch_classify.sv
`timescale 1ns/1ps
module move_fetch_classify
    import move_fetch_pkg::*;
#(
    parameter logic [UNIT_W-1:0] UNIT_ADDR = 8'h01
) (
    input  logic              in_flight,
    input  logic              payload_next,
    input  logic [WORD_W-1:0] word,
    input  logic              stall,
    input  logic              jump,
    output ret_kind_e         kind,
    output logic              chain_long
);

    logic live;

    always_comb begin
        live = in_flight && !stall && !jump;
        if (!live)
            kind = RET_NONE;
        else if (payload_next)
            kind = RET_LONG;
        else if (is_short_lit(word))
            kind = RET_SHORT;
        else
            kind = RET_INSTR;
        chain_long = (kind == RET_INSTR) && is_long_load(word, UNIT_ADDR);
    end

endmodule

// File: rtl/move_fetch_seq.sv
`timescale 1ns/1ps
module move_fetch_seq
    import move_fetch_pkg::*;
#(
    parameter int IMEM_AW = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               stall,
    input  logic               jump,
    input  logic [WORD_W-1:0]  jump_target,
    input  logic               chain_long,
    output logic               imem_en,
    output logic [IMEM_AW-1:0] imem_addr,
    output logic [WORD_W-1:0]  pc_q,
    output logic               in_flight_q,
    output logic               payload_next_q
);

    logic issue;

    always_comb begin
        issue     = !rst && !stall && !jump;
        imem_en   = issue;
        imem_addr = pc_q[IMEM_AW-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q           <= '0;
            in_flight_q    <= 1'b0;
            payload_next_q <= 1'b0;
        end else if (stall) begin
            pc_q           <= pc_q;
            in_flight_q    <= in_flight_q;
            payload_next_q <= payload_next_q;
        end else if (jump) begin
            pc_q           <= jump_target;
            in_flight_q    <= 1'b0;
            payload_next_q <= 1'b0;
        end else begin
            pc_q           <= pc_q + WORD_W'(1);
            in_flight_q    <= 1'b1;
            payload_next_q <= chain_long;
        end
    end

endmodule

// File: rtl/move_fetch_lit.sv
`timescale 1ns/1ps
module move_fetch_lit
    import move_fetch_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  ret_kind_e         kind,
    input  logic [WORD_W-1:0] word,
    output logic [WORD_W-1:0] lit_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            lit_q <= '0;
        end else begin
            unique case (kind)
                RET_LONG:  lit_q <= word;
                RET_SHORT: lit_q <= short_value(word);
                default:   lit_q <= lit_q;
            endcase
        end
    end

endmodule

// File: rtl/move_fetch_unit.sv
`timescale 1ns/1ps
module move_fetch_unit
    import move_fetch_pkg::*;
#(
    parameter logic [7:0] UNIT_ADDR = 8'h01,
    parameter int         IMEM_AW   = 10
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               stall,
    output logic               imem_en,
    output logic [IMEM_AW-1:0] imem_addr,
    input  logic [31:0]        imem_data,
    output logic               instr_valid,
    output logic [31:0]        instr_word,
    input  logic               wr_en,
    input  logic [7:0]         wr_unit,
    input  logic [3:0]         wr_sub,
    input  logic [31:0]        wr_data,
    input  logic [7:0]         rd_unit,
    input  logic [3:0]         rd_sub,
    output logic [31:0]        rd_data,
    output logic               rd_hit
);

    logic [WORD_W-1:0] pc_q;
    logic [WORD_W-1:0] lit_q;
    logic              in_flight_q;
    logic              payload_next_q;
    logic              jump;
    logic [WORD_W-1:0] jump_target;
    logic              chain_long;
    ret_kind_e         kind;

    move_fetch_bus_port #(.UNIT_ADDR(UNIT_ADDR)) u_port (
        .stall       (stall),
        .wr_en       (wr_en),
        .wr_unit     (wr_unit),
        .wr_sub      (wr_sub),
        .wr_data     (wr_data),
        .rd_unit     (rd_unit),
        .rd_sub      (rd_sub),
        .pc_val      (pc_q),
        .lit_val     (lit_q),
        .jump        (jump),
        .jump_target (jump_target),
        .rd_data     (rd_data),
        .rd_hit      (rd_hit)
    );

    move_fetch_classify #(.UNIT_ADDR(UNIT_ADDR)) u_classify (
        .in_flight    (in_flight_q),
        .payload_next (payload_next_q),
        .word         (imem_data),
        .stall        (stall),
        .jump         (jump),
        .kind         (kind),
        .chain_long   (chain_long)
    );

    move_fetch_seq #(.IMEM_AW(IMEM_AW)) u_seq (
        .clk            (clk),
        .rst            (rst),
        .stall          (stall),
        .jump           (jump),
        .jump_target    (jump_target),
        .chain_long     (chain_long),
        .imem_en        (imem_en),
        .imem_addr      (imem_addr),
        .pc_q           (pc_q),
        .in_flight_q    (in_flight_q),
        .payload_next_q (payload_next_q)
    );

    move_fetch_lit u_lit (
        .clk   (clk),
        .rst   (rst),
        .kind  (kind),
        .word  (imem_data),
        .lit_q (lit_q)
    );

    always_comb begin
        instr_valid = (kind == RET_INSTR);
        instr_word  = imem_data;
    end

endmodule

// File: rtl/move_fetch_unit_chk.sv
`timescale 1ns/1ps
module move_fetch_unit_chk
    import move_fetch_pkg::*;
#(
    parameter logic [7:0] UNIT_ADDR = 8'h01
) (
    input logic        clk,
    input logic        rst,
    input logic        stall,
    input logic        imem_en,
    input logic [31:0] imem_data,
    input logic        instr_valid,
    input logic        wr_en,
    input logic [7:0]  wr_unit,
    input logic [3:0]  wr_sub,
    input logic [31:0] wr_data,
    input logic [31:0] rd_data,
    input logic        rd_hit,
    input logic [31:0] pc_q,
    input logic [31:0] lit_q,
    input ret_kind_e   kind
);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (pc_q == 32'd0 && lit_q == 32'd0)); // R1

    AST_FETCH_STEP: assert property (@(posedge clk) disable iff (rst)
        imem_en |=> (pc_q == $past(pc_q) + 32'd1)); // R2

    AST_SHORT_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (kind == RET_SHORT) |=> (lit_q == {4'b0, $past(imem_data[27:0])})); // R3

    AST_LONG_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        (kind == RET_LONG) |=> (lit_q == $past(imem_data))); // R4

    AST_PAYLOAD_HIDDEN: assert property (@(posedge clk) disable iff (rst)
        $onehot0({instr_valid, kind == RET_LONG, kind == RET_SHORT})); // R4

    AST_JUMP_TARGET: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !stall && wr_unit == UNIT_ADDR && wr_sub == 4'd0)
        |=> (pc_q == $past(wr_data) && !instr_valid)); // R5

    AST_LIT_ONLY_FROM_STREAM: assert property (@(posedge clk) disable iff (rst)
        (kind != RET_SHORT && kind != RET_LONG) |=> $stable(lit_q)); // R6

    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        !rd_hit |-> (rd_data == 32'd0)); // R7

    AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (rst)
        stall |=> ($stable(pc_q) && $stable(lit_q))); // R8

endmodule

bind move_fetch_unit move_fetch_unit_chk #(.UNIT_ADDR(UNIT_ADDR)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .stall       (stall),
    .imem_en     (imem_en),
    .imem_data   (imem_data),
    .instr_valid (instr_valid),
    .wr_en       (wr_en),
    .wr_unit     (wr_unit),
    .wr_sub      (wr_sub),
    .wr_data     (wr_data),
    .rd_data     (rd_data),
    .rd_hit      (rd_hit),
    .pc_q        (pc_q),
    .lit_q       (lit_q),
    .kind        (kind)
);

// File: tb/tb_move_fetch_unit.sv
`timescale 1ns/1ps
module tb_move_fetch_unit;

    localparam logic [7:0] UNIT = 8'h01;
    localparam int AW    = 10;
    localparam int DEPTH = 1 << AW;
    localparam int PROG  = 300;
    localparam logic [31:0] NOP = 32'h0200_2100;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            stall = 1'b0;
    logic            imem_en;
    logic [AW-1:0]   imem_addr;
    logic [31:0]     imem_data = '0;
    logic            instr_valid;
    logic [31:0]     instr_word;
    logic            wr_en = 1'b0;
    logic [7:0]      wr_unit = '0;
    logic [3:0]      wr_sub = '0;
    logic [31:0]     wr_data = '0;
    logic [7:0]      rd_unit = UNIT;
    logic [3:0]      rd_sub = '0;
    logic [31:0]     rd_data;
    logic            rd_hit;

    logic [31:0] mem [DEPTH];
    logic [31:0] exp_instr [PROG];
    logic [31:0] exp_lit [PROG];
    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    always_ff @(posedge clk) begin
        if (imem_en) imem_data <= mem[imem_addr];
    end

    move_fetch_unit #(.UNIT_ADDR(UNIT), .IMEM_AW(AW)) dut (
        .clk(clk), .rst(rst), .stall(stall),
        .imem_en(imem_en), .imem_addr(imem_addr), .imem_data(imem_data),
        .instr_valid(instr_valid), .instr_word(instr_word),
        .wr_en(wr_en), .wr_unit(wr_unit), .wr_sub(wr_sub), .wr_data(wr_data),
        .rd_unit(rd_unit), .rd_sub(rd_sub), .rd_data(rd_data), .rd_hit(rd_hit)
    );

    function automatic logic [31:0] mk_long(input logic [3:0] cond);
        return {cond, UNIT, 4'd1, 8'h22, 8'h00};
    endfunction

    function automatic logic ref_is_long(input logic [31:0] w);
        return (w[31:28] != 4'hF) && (w[27:20] == UNIT) && (w[19:16] == 4'd1);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic settle();
        #1;
    endtask

    task automatic read_chk(input string req, input logic [3:0] sub, input logic [31:0] exp);
        rd_sub = sub;
        settle();
        check(req, {31'b0, rd_hit}, 32'd1);
        check(req, rd_data, exp);
    endtask

    task automatic fill_nops();
        for (int i = 0; i < DEPTH; i++) mem[i] = NOP | 32'(i[7:0]);
    endtask

    task automatic directed();
        fill_nops();
        mem[0] = 32'h0300_4100;
        mem[1] = 32'hF0AB_CDE1;
        mem[2] = mk_long(4'd2);
        mem[3] = 32'hF123_4567;
        mem[4] = 32'h0400_5100;
        rst = 1'b1;
        repeat (3) tick();
        settle();
        check("R1 no fetch in reset", {31'b0, imem_en}, 32'd0);
        check("R1 nothing presented in reset", {31'b0, instr_valid}, 32'd0);
        read_chk("R1 pc zero / R7", 4'd0, 32'd0);
        read_chk("R1 lit zero / R7", 4'd1, 32'd0);
        tick();                              // P0
        rst = 1'b0;
        settle();
        check("R1 first fetch enable", {31'b0, imem_en}, 32'd1);
        check("R1 first fetch address", 32'(imem_addr), 32'd0);
        tick();                              // P1
        settle();
        check("R2 word0 valid", {31'b0, instr_valid}, 32'd1);
        check("R2 word0 data", instr_word, mem[0]);
        check("R2 pc step", 32'(imem_addr), 32'd1);
        tick();                              // P2: short literal returns
        settle();
        check("R3 short not presented", {31'b0, instr_valid}, 32'd0);
        tick();                              // P3
        read_chk("R3 short zero-extended", 4'd1, 32'h00AB_CDE1);
        check("R4 long load presented", {31'b0, instr_valid}, 32'd1);
        check("R4 long load word", instr_word, mem[2]);
        tick();                              // P4: payload returns
        settle();
        check("R4 payload hidden", {31'b0, instr_valid}, 32'd0);
        tick();                              // P5
        read_chk("R4 payload whole", 4'd1, 32'hF123_4567);
        check("R2 word4 valid", {31'b0, instr_valid}, 32'd1);
        check("R2 word4 data", instr_word, mem[4]);
        stall = 1'b1;
        wr_en = 1'b1; wr_unit = UNIT; wr_sub = 4'd0; wr_data = 32'h80;
        settle();
        check("R8 stall hides word", {31'b0, instr_valid}, 32'd0);
        check("R8 stall no fetch", {31'b0, imem_en}, 32'd0);
        repeat (3) tick();
        read_chk("R8 pc held, write ignored", 4'd0, 32'd5);
        read_chk("R8 lit held", 4'd1, 32'hF123_4567);
        check("R8 word held", instr_word, mem[4]);
        wr_en = 1'b0;
        stall = 1'b0;
        settle();
        check("R8 word re-presented", {31'b0, instr_valid}, 32'd1);
        check("R8 word re-presented data", instr_word, mem[4]);
        check("R8 resume address", 32'(imem_addr), 32'd5);
        tick();
        wr_en = 1'b1; wr_unit = UNIT; wr_sub = 4'd0; wr_data = 32'h40;
        settle();
        check("R5 returning word dropped", {31'b0, instr_valid}, 32'd0);
        check("R5 no fetch on jump", {31'b0, imem_en}, 32'd0);
        tick();
        wr_en = 1'b0;
        settle();
        check("R5 fetch target", 32'(imem_addr), 32'h40);
        check("R5 bubble", {31'b0, instr_valid}, 32'd0);
        read_chk("R5 pc is target", 4'd0, 32'h40);
        tick();
        settle();
        check("R5 target word valid", {31'b0, instr_valid}, 32'd1);
        check("R5 target word", instr_word, mem[32'h40]);
        wr_en = 1'b1; wr_unit = UNIT; wr_sub = 4'd1; wr_data = 32'h1234_5678;
        tick();
        wr_sub = 4'd5; wr_data = 32'h0000_0300;
        tick();
        wr_en = 1'b0;
        read_chk("R6 lit write ignored", 4'd1, 32'hF123_4567);
        read_chk("R6 no jump from other subunit", 4'd0, 32'h43);
        rd_unit = UNIT + 8'd1; rd_sub = 4'd0;
        settle();
        check("R7 other unit no hit", {31'b0, rd_hit}, 32'd0);
        check("R7 other unit zero", rd_data, 32'd0);
        rd_unit = UNIT; rd_sub = 4'd2;
        settle();
        check("R7 other subunit no hit", {31'b0, rd_hit}, 32'd0);
        check("R7 other subunit zero", rd_data, 32'd0);
    endtask

    task automatic random_run();
        int i;
        int n;
        int idx;
        int cyc;
        logic pend;
        logic [31:0] lit;
        logic [31:0] w;
        int r;
        rst = 1'b1;
        fill_nops();
        i = 0;
        while (i < PROG) begin
            r = int'($urandom % 8);
            if (r < 2) begin
                mem[i] = {4'hF, 28'($urandom)};
                i++;
            end else if (r < 4 && i < PROG - 1) begin
                mem[i] = mk_long(4'($urandom % 15));
                mem[i+1] = $urandom;
                i += 2;
            end else begin
                w = $urandom;
                w[31:28] = 4'($urandom % 15);
                if (ref_is_long(w)) w[19:16] = 4'd2;
                mem[i] = w;
                i++;
            end
        end
        n = 0; pend = 1'b0; lit = '0;
        for (int j = 0; j < PROG; j++) begin
            if (pend) begin
                lit = mem[j];
                pend = 1'b0;
            end else if (mem[j][31:28] == 4'hF) begin
                lit = {4'b0, mem[j][27:0]};
            end else begin
                exp_instr[n] = mem[j];
                exp_lit[n] = lit;
                n++;
                pend = ref_is_long(mem[j]);
            end
        end
        repeat (2) tick();
        rst = 1'b0;
        rd_unit = UNIT; rd_sub = 4'd1;
        idx = 0; cyc = 0;
        while (idx < n && cyc < 20000) begin
            tick();
            stall = (($urandom % 4) == 0);
            settle();
            if (instr_valid) begin
                check("R2/R4 stream word", instr_word, exp_instr[idx]);
                check("R3/R4 lit at word", rd_data, exp_lit[idx]);
                idx++;
            end
            cyc++;
        end
        stall = 1'b0;
        check("R2 stream complete", 32'(idx), 32'(n));
    endtask

    initial begin
        void'($urandom(32'd1234));
        directed();
        random_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule